// File: doc/BRIEF.md
# Instruction-Controlled Watchdog Timer

This block is the watchdog of a small microcontroller core. It counts machine-cycle enable pulses and is steered by single-cycle strobes from the instruction decoder. One strobe is a restart, one is a disable, and one marks that some other instruction has executed. The watchdog starts counting as soon as reset is released. Software has to restart it often enough to keep the counter from wrapping.

The first wrap of the counter sets a first-stage overflow flag. A restart clears that flag. If the flag was set when the restart arrived, the block also asks the core to skip the following instruction. A second wrap while the flag is still set raises a one-cycle system-reset request. The only way to stop the watchdog is a disable instruction followed, as the very next instruction, by a restart. While the core sits in RAM back-up mode, the counter is frozen. The enable state survives both entry into and exit from back-up.

Top module: `insn_watchdog`

## Requirements
- R1: During reset and in the first cycle after it, `wd_enabled` is 1 and `count`, `ovf_flag`, `skip_req` and `sys_rst_req` are all 0.
- R2: While enabled and not in back-up, `count` rises by exactly 1 in the cycle after each cycle with `mc_tick` high. It holds its value in cycles without a tick.
- R3: A tick while `count` is all ones returns `count` to 0 and sets `ovf_flag` if it was clear. In that case no reset request is raised.
- R4: A tick while `count` is all ones and `ovf_flag` is already set raises `sys_rst_req` for exactly one cycle. `ovf_flag` stays set.
- R5: A restart strobe clears `count` and `ovf_flag` in the next cycle. If restarts come before the counter wraps, no reset request ever appears.
- R6: `skip_req` is high for one cycle, the cycle after a restart, exactly when `ovf_flag` was 1 in the restart cycle. It is low at every other time.
- R7: A disable strobe followed directly, as the next strobe, by a restart strobe drops `wd_enabled` to 0. After that, `count` no longer advances. Tick-only cycles between the two strobes do not break the pair.
- R8: A disable strobe followed by an other-instruction strobe cancels the pending disable. A later restart then leaves `wd_enabled` at 1.
- R9: A restart strobe with no disable pending sets `wd_enabled` to 1. This also turns a stopped watchdog back on.
- R10: `bkup_enter` freezes `count` from the next cycle on, until `bkup_exit` is seen. Counting then resumes from the held value, and neither event changes `wd_enabled` or `ovf_flag`.
- R11: If more than one strobe is high in the same cycle, restart wins over disable, and disable wins over other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| mc_tick | input | 1 | Machine-cycle enable pulse |
| insn_restart | input | 1 | Restart instruction executed (one cycle) |
| insn_disable | input | 1 | Disable instruction executed (one cycle) |
| insn_other | input | 1 | Any other instruction executed (one cycle) |
| bkup_enter | input | 1 | Core enters RAM back-up mode |
| bkup_exit | input | 1 | Core leaves RAM back-up mode |
| wd_enabled | output | 1 | Watchdog is counting |
| ovf_flag | output | 1 | First-stage overflow flag |
| skip_req | output | 1 | Skip the next instruction (one cycle) |
| sys_rst_req | output | 1 | System-reset request (one cycle) |
| count | output | CNT_W | Current counter value |

## Verification
The bench checks that the disable pairing counts instructions, not cycles. A design that cleared the pending state on idle cycles would fail to stop after tick-only gaps. A design that kept the pending state through an other-instruction strobe would wrongly stop the watchdog. The bench checks that the skip request follows only a restart that meets a set flag; a design that sampled the flag after clearing it would never skip. It also checks that the first wrap raises no reset while the second one does, so a one-stage design would be caught. Finally, it checks that back-up holds the count without losing the enable state.

// File: rtl/iwdt_pkg.sv
package iwdt_pkg;

    typedef enum logic [1:0] {
        INSN_NONE    = 2'd0,
        INSN_RESTART = 2'd1,
        INSN_DISABLE = 2'd2,
        INSN_OTHER   = 2'd3
    } insn_e;

    typedef struct packed {
        logic enabled;
        logic dis_armed;
        logic in_backup;
    } ctl_state_t;

    typedef struct packed {
        logic flag;
        logic skip;
        logic rst_req;
    } ovf_state_t;

    localparam ctl_state_t CTL_RESET = '{enabled: 1'b1, dis_armed: 1'b0, in_backup: 1'b0};
    localparam ovf_state_t OVF_RESET = '{flag: 1'b0, skip: 1'b0, rst_req: 1'b0};

    // Restart has top priority, then disable, then any other instruction.
    function automatic insn_e decode_insn(input logic rs, input logic ds, input logic ot);
        insn_e r;
        if (rs)      r = INSN_RESTART;
        else if (ds) r = INSN_DISABLE;
        else if (ot) r = INSN_OTHER;
        else         r = INSN_NONE;
        return r;
    endfunction

endpackage

// File: rtl/iwdt_ctrl.sv
module iwdt_ctrl
    import iwdt_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  insn_e insn,
    input  logic  bkup_enter,
    input  logic  bkup_exit,
    output logic  enabled,
    output logic  in_backup
);

    ctl_state_t cur, nxt;

    always_comb begin
        nxt = cur;
        unique case (insn)
            INSN_RESTART: begin
                nxt.enabled   = !cur.dis_armed;
                nxt.dis_armed = 1'b0;
            end
            INSN_DISABLE: nxt.dis_armed = 1'b1;
            INSN_OTHER:   nxt.dis_armed = 1'b0;
            default:      ;
        endcase
        if (bkup_exit)       nxt.in_backup = 1'b0;
        else if (bkup_enter) nxt.in_backup = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cur <= CTL_RESET;
        else     cur <= nxt;
    end

    assign enabled   = cur.enabled;
    assign in_backup = cur.in_backup;

endmodule

// File: rtl/iwdt_counter.sv
module iwdt_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             clear,
    output logic [CNT_W-1:0] count,
    output logic             wrap
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;

    assign wrap = run && !clear && (cnt_q == CNT_MAX);

    always_ff @(posedge clk) begin
        if (rst || clear) cnt_q <= '0;
        else if (run)     cnt_q <= cnt_q + 1'b1;
    end

    assign count = cnt_q;

endmodule

// File: rtl/iwdt_ovf.sv
module iwdt_ovf
    import iwdt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic wrap,
    output logic flag,
    output logic skip,
    output logic rst_req
);

    ovf_state_t cur, nxt;

    always_comb begin
        nxt.skip    = restart && cur.flag;
        nxt.rst_req = wrap && cur.flag;
        if (restart)   nxt.flag = 1'b0;
        else if (wrap) nxt.flag = 1'b1;
        else           nxt.flag = cur.flag;
    end

    always_ff @(posedge clk) begin
        if (rst) cur <= OVF_RESET;
        else     cur <= nxt;
    end

    assign flag    = cur.flag;
    assign skip    = cur.skip;
    assign rst_req = cur.rst_req;

endmodule

// File: rtl/insn_watchdog.sv
module insn_watchdog
    import iwdt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mc_tick,
    input  logic             insn_restart,
    input  logic             insn_disable,
    input  logic             insn_other,
    input  logic             bkup_enter,
    input  logic             bkup_exit,
    output logic             wd_enabled,
    output logic             ovf_flag,
    output logic             skip_req,
    output logic             sys_rst_req,
    output logic [CNT_W-1:0] count
);

    insn_e insn;
    logic  restart;
    logic  in_backup;
    logic  run;
    logic  wrap;

    assign insn    = decode_insn(insn_restart, insn_disable, insn_other);
    assign restart = (insn == INSN_RESTART);
    assign run     = wd_enabled && mc_tick && !in_backup;

    iwdt_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .insn       (insn),
        .bkup_enter (bkup_enter),
        .bkup_exit  (bkup_exit),
        .enabled    (wd_enabled),
        .in_backup  (in_backup)
    );

    iwdt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .run   (run),
        .clear (restart),
        .count (count),
        .wrap  (wrap)
    );

    iwdt_ovf u_ovf (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .wrap    (wrap),
        .flag    (ovf_flag),
        .skip    (skip_req),
        .rst_req (sys_rst_req)
    );

endmodule

// File: rtl/insn_watchdog_chk.sv
module insn_watchdog_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             mc_tick,
    input logic             insn_restart,
    input logic             wd_enabled,
    input logic             ovf_flag,
    input logic             skip_req,
    input logic             sys_rst_req,
    input logic [CNT_W-1:0] count
);

    // R5
    restart_clears_chk: assert property (@(posedge clk) disable iff (rst)
        insn_restart |=> (!ovf_flag && count == '0));

    // R6
    skip_on_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (insn_restart && ovf_flag) |=> skip_req);

    // R6
    no_spurious_skip_chk: assert property (@(posedge clk) disable iff (rst)
        !(insn_restart && ovf_flag) |=> !skip_req);

    // R4
    reset_needs_flag_chk: assert property (@(posedge clk) disable iff (rst)
        sys_rst_req |-> ovf_flag);

    // R4
    reset_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        sys_rst_req |=> !sys_rst_req);

    // R7
    stop_only_by_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (wd_enabled && !insn_restart) |=> wd_enabled);

    // R7
    stopped_holds_count_chk: assert property (@(posedge clk) disable iff (rst)
        (!wd_enabled && !insn_restart) |=> $stable(count));

    // R2
    idle_holds_count_chk: assert property (@(posedge clk) disable iff (rst)
        (!mc_tick && !insn_restart) |=> $stable(count));

endmodule

bind insn_watchdog insn_watchdog_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .mc_tick      (mc_tick),
    .insn_restart (insn_restart),
    .wd_enabled   (wd_enabled),
    .ovf_flag     (ovf_flag),
    .skip_req     (skip_req),
    .sys_rst_req  (sys_rst_req),
    .count        (count)
);

// File: tb/insn_watchdog_tb.sv
module insn_watchdog_tb;

    localparam int W    = 8;
    localparam int MAXV = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         mc_tick = 0, insn_restart = 0, insn_disable = 0, insn_other = 0;
    logic         bkup_enter = 0, bkup_exit = 0;
    logic         wd_enabled, ovf_flag, skip_req, sys_rst_req;
    logic [W-1:0] count;

    int checks = 0;
    int errors = 0;
    int rr_seen = 0;
    bit started = 0;
    bit done = 0;

    // reference model state
    bit m_en = 1, m_ovf = 0, m_pend = 0, m_bk = 0, m_skip = 0, m_rr = 0;
    int m_cnt = 0;

    always #2 clk = ~clk;

    insn_watchdog #(.CNT_W(W)) u_dut (
        .clk(clk), .rst(rst), .mc_tick(mc_tick),
        .insn_restart(insn_restart), .insn_disable(insn_disable), .insn_other(insn_other),
        .bkup_enter(bkup_enter), .bkup_exit(bkup_exit),
        .wd_enabled(wd_enabled), .ovf_flag(ovf_flag), .skip_req(skip_req),
        .sys_rst_req(sys_rst_req), .count(count)
    );

    always @(posedge clk) begin
        bit r, d, o, n_en, n_ovf, n_pend, n_bk;
        int n_cnt;
        started <= 1'b1;
        if (rst) begin
            m_en = 1; m_ovf = 0; m_pend = 0; m_bk = 0; m_skip = 0; m_rr = 0; m_cnt = 0;
        end else begin
            r = insn_restart;
            d = insn_disable && !r;
            o = insn_other && !r && !d;
            n_en = m_en; n_ovf = m_ovf; n_cnt = m_cnt; n_pend = m_pend; n_bk = m_bk;
            m_skip = r && m_ovf;
            m_rr = 0;
            if (r) begin
                n_cnt = 0; n_ovf = 0; n_en = !m_pend; n_pend = 0;
            end else if (m_en && mc_tick && !m_bk) begin
                if (m_cnt == MAXV) begin
                    n_cnt = 0;
                    if (m_ovf) m_rr = 1; else n_ovf = 1;
                end else begin
                    n_cnt = m_cnt + 1;
                end
            end
            if (d) n_pend = 1;
            else if (o) n_pend = 0;
            if (bkup_exit) n_bk = 0;
            else if (bkup_enter) n_bk = 1;
            m_en = n_en; m_ovf = n_ovf; m_cnt = n_cnt; m_pend = n_pend; m_bk = n_bk;
        end
    end

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (started && !done) begin
            check("R2 count",        int'(count),       m_cnt);
            check("R3 ovf_flag",     int'(ovf_flag),    int'(m_ovf));
            check("R4 sys_rst_req",  int'(sys_rst_req), int'(m_rr));
            check("R6 skip_req",     int'(skip_req),    int'(m_skip));
            check("R7 wd_enabled",   int'(wd_enabled),  int'(m_en));
            if (sys_rst_req === 1'b1) rr_seen++;
        end
    end

    task automatic cyc(bit r, bit d, bit o, bit t, bit be = 0, bit bx = 0);
        @(posedge clk);
        #1;
        insn_restart = r; insn_disable = d; insn_other = o;
        mc_tick = t; bkup_enter = be; bkup_exit = bx;
    endtask

    task automatic idle(int n, bit t);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, t);
    endtask

    task automatic settle();
        cyc(0, 0, 0, 0);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int held;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        // R1: reset state
        check("R1 enabled", int'(wd_enabled), 1);
        check("R1 count", int'(count), 0);
        check("R1 flags", int'({ovf_flag, skip_req, sys_rst_req}), 0);

        // R5: periodic restarts never reach a reset
        for (int k = 0; k < 8; k++) begin
            idle(200, 1);
            cyc(1, 0, 0, 0);
        end
        settle();
        check("R5 no reset", rr_seen, 0);
        check("R5 flag clear", int'(ovf_flag), 0);

        // R2: gated ticks, every other cycle
        for (int k = 0; k < 20; k++) begin cyc(0, 0, 0, 1); cyc(0, 0, 0, 0); end
        settle();
        check("R2 half ticks", int'(count), 20);

        // R6: restart with flag clear gives no skip
        cyc(1, 0, 0, 0);
        settle();
        check("R6 no skip", int'(skip_req), 0);

        // R3: first wrap sets flag, no reset
        idle(MAXV + 1, 1);
        settle();
        check("R3 flag set", int'(ovf_flag), 1);
        check("R3 count wrapped", int'(count), 0);
        check("R3 no reset", rr_seen, 0);

        // R6: restart with flag set asks for a skip
        cyc(1, 0, 0, 0);
        cyc(0, 0, 0, 0);
        @(negedge clk);
        check("R6 skip", int'(skip_req), 1);
        check("R5 flag cleared", int'(ovf_flag), 0);
        settle();
        check("R6 skip one cycle", int'(skip_req), 0);

        // R4: second wrap raises reset request
        idle(2 * (MAXV + 1), 1);
        cyc(0, 0, 0, 0);
        @(negedge clk);
        check("R4 reset req", int'(sys_rst_req), 1);
        check("R4 flag kept", int'(ovf_flag), 1);
        settle();
        check("R4 single pulse", int'(sys_rst_req), 0);
        check("R4 pulse count", rr_seen, 1);

        // R8: disable then other keeps watchdog on
        cyc(1, 0, 0, 0);
        cyc(0, 1, 0, 0);
        cyc(0, 0, 1, 0);
        cyc(1, 0, 0, 0);
        idle(10, 1);
        settle();
        check("R8 still enabled", int'(wd_enabled), 1);
        check("R8 counting", int'(count), 10);

        // R11: restart beats disable when both arrive together
        cyc(1, 1, 0, 0);
        cyc(1, 0, 0, 0);
        settle();
        check("R11 restart priority", int'(wd_enabled), 1);

        // R7: disable, tick-only cycles, restart stops the watchdog
        cyc(0, 1, 0, 0);
        idle(5, 1);
        cyc(1, 0, 0, 0);
        idle(300, 1);
        settle();
        check("R7 disabled", int'(wd_enabled), 0);
        check("R7 count frozen", int'(count), 0);
        check("R7 no flag", int'(ovf_flag), 0);

        // R9: plain restart turns it back on
        cyc(1, 0, 0, 0);
        idle(7, 1);
        settle();
        check("R9 re-enabled", int'(wd_enabled), 1);
        check("R9 counting", int'(count), 7);

        // R10: back-up holds count and keeps enable
        cyc(1, 0, 0, 0);
        idle(50, 1);
        cyc(0, 0, 0, 0, 1, 0);
        idle(100, 1);
        settle();
        held = int'(count);
        check("R10 held", held, 50);
        check("R10 enabled in backup", int'(wd_enabled), 1);
        cyc(0, 0, 0, 0, 0, 1);
        idle(10, 1);
        settle();
        check("R10 resumed", int'(count), 60);
        check("R10 enabled after", int'(wd_enabled), 1);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule